// File: doc/BRIEF.md
# External Bus Access Timing Sequencer

This block turns one 32-bit request into the strobe sequence of an external bus access. Timing comes from two words that the block samples with the request: a per-region delay/size word and a shared common-delay word. Every transfer always has a strobe phase whose length is an encoded read or write delay. Around it, the region word can switch on four more phases, and each of them takes its length from one field of the common-delay word. A DMA access can replace the normal delay with its own value and can force a full-width transfer.

When the bus is narrower than the request, the block splits the request into byte or halfword transfers. It can step the address between transfers. It collects read data into one 32-bit word. A region can also hold the strobe until an external device reports ready. When the access finishes, `done_o` pulses for one cycle. `rdata_o` holds the assembled read word until the next request.

Top module: `ebus_access_seq`

## Requirements
- R1: While reset is held and after it is released, both strobes `bus_rd_n_o`/`bus_wr_n_o` are high (inactive) and `busy_o` and `done_o` are low.
- R2: The strobe is active (low) for N+1 cycles per transfer. N is region bits [3:0] for a write and region bits [7:4] for a read. Only `bus_wr_n_o` falls for a write and only `bus_rd_n_o` for a read. Both are never low together, and neither is low while the block is idle.
- R3: Each transfer runs its phases in this order: pre-strobe, strobe, hold, floating release, recovery. Pre-strobe is enabled by region bit 11 and lasts common[15:12] cycles. Hold is enabled by bit 9 and lasts common[7:4] cycles. Floating release is enabled by bit 10 and lasts common[11:8] cycles. Recovery is enabled by bit 8 and lasts common[3:0] cycles. A phase that is disabled or has zero length takes no cycles.
- R4: Region bit 12 selects the bus width: 0 gives 8 bits and 1 gives 16 bits. A request is split into 4 or 2 transfers, least-significant part first. Write data for each transfer appears on the low bits of `bus_data_o`. Read data taken from the low bits of `bus_data_i` at the last strobe cycle is placed into `rdata_o` at the matching position.
- R5: When `dma_i` is high and region bit 29 is set, the strobe lasts region[27:24]+1 cycles instead of the read/write delay. Without `dma_i`, bits 29 and 24-27 have no effect.
- R6: When `dma_i` is high and region bit 30 is set, the access is one 32-bit transfer, whatever bit 12 says. Without `dma_i`, bit 30 has no effect.
- R7: With region bit 13 set, `bus_addr_o` steps by the transfer width in bytes (1 or 2) between transfers. With it clear, the address stays at the requested value.
- R8: With region bit 31 set, the strobe stays active after its count has run out until `ready_i` is sampled high. With bit 31 clear, `ready_i` has no effect.
- R9: A request sampled while idle starts the access. `busy_o` stays high until `done_o` has pulsed for exactly one cycle. That pulse comes K·T+1 cycles after the request edge, where K is the number of transfers and T is the phase cycles per transfer. A request while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| dma_i | input | 1 | Access comes from DMA |
| addr_i | input | ADDR_W | Start address |
| wdata_i | input | 32 | Write word |
| region_cfg_i | input | 32 | Per-region delay/size word |
| common_cfg_i | input | 16 | Shared phase lengths |
| ready_i | input | 1 | External device ready |
| bus_data_i | input | 32 | Read data from the bus |
| bus_rd_n_o | output | 1 | Read strobe, active low |
| bus_wr_n_o | output | 1 | Write strobe, active low |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_data_o | output | 32 | Write data, current part on the low bits |
| bus_data_oe_o | output | 1 | Write data drive enable |
| rdata_o | output | 32 | Assembled read word |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset starts the block in idle. They also assume that `req_i` is the only way out of idle, so they can treat any strobe or busy cycle that is not preceded by an accepted request as an error. The bench drives every input at the falling edge and holds the configuration words steady for the whole access. It raises `req_i` for one cycle to start an access, and once more in the middle of an access, to show that a request while busy is ignored. `ready_i` is held low throughout the vector table, so the regions without the wait bit also show that it is ignored.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  localparam int BUS_W = 32;

  // region word bit positions
  localparam int B_RECOV = 8;
  localparam int B_HOLD  = 9;
  localparam int B_FLOAT = 10;
  localparam int B_PRE   = 11;
  localparam int B_WIDE  = 12;
  localparam int B_INC   = 13;
  localparam int B_DSEL  = 29;
  localparam int B_D32   = 30;
  localparam int B_WAIT  = 31;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_STROBE, PH_HOLD, PH_FLOAT, PH_RECOV, PH_DONE
  } phase_e;

  typedef enum logic [1:0] {
    WID_8, WID_16, WID_32
  } width_e;

  typedef struct packed {
    logic [3:0] pre;
    logic [4:0] strobe;
    logic [3:0] hold;
    logic [3:0] flt;
    logic [3:0] recov;
    logic       wait_en;
    logic       autoinc;
    width_e     wsel;
  } timing_t;

  function automatic logic [4:0] phase_len(phase_e ph, timing_t t);
    logic [4:0] l;
    case (ph)
      PH_PRE:    l = {1'b0, t.pre};
      PH_STROBE: l = t.strobe;
      PH_HOLD:   l = {1'b0, t.hold};
      PH_FLOAT:  l = {1'b0, t.flt};
      PH_RECOV:  l = {1'b0, t.recov};
      default:   l = 5'd1;
    endcase
    return l;
  endfunction

  function automatic logic [1:0] last_index(width_e w);
    logic [1:0] r;
    case (w)
      WID_8:   r = 2'd3;
      WID_16:  r = 2'd1;
      default: r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ebus_rst_sync.sv
module ebus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ebus_timing_decode.sv
module ebus_timing_decode
  import ebus_pkg::*;
(
  input  logic [31:0] region_cfg_i,
  input  logic [15:0] common_cfg_i,
  input  logic        wr_i,
  input  logic        dma_i,
  output timing_t     tim_o
);
  logic [3:0] dly_sel;
  logic       unused_cfg;

  assign unused_cfg = ^{region_cfg_i[23:14], region_cfg_i[28]};

  always_comb begin
    if (dma_i && region_cfg_i[B_DSEL]) dly_sel = region_cfg_i[27:24];
    else if (wr_i)                     dly_sel = region_cfg_i[3:0];
    else                               dly_sel = region_cfg_i[7:4];

    tim_o.strobe  = {1'b0, dly_sel} + 5'd1;
    tim_o.pre     = region_cfg_i[B_PRE]   ? common_cfg_i[15:12] : 4'd0;
    tim_o.hold    = region_cfg_i[B_HOLD]  ? common_cfg_i[7:4]   : 4'd0;
    tim_o.flt     = region_cfg_i[B_FLOAT] ? common_cfg_i[11:8]  : 4'd0;
    tim_o.recov   = region_cfg_i[B_RECOV] ? common_cfg_i[3:0]   : 4'd0;
    tim_o.wait_en = region_cfg_i[B_WAIT];
    tim_o.autoinc = region_cfg_i[B_INC];
    if (dma_i && region_cfg_i[B_D32]) tim_o.wsel = WID_32;
    else if (region_cfg_i[B_WIDE])    tim_o.wsel = WID_16;
    else                              tim_o.wsel = WID_8;
  end
endmodule

// File: rtl/ebus_phase_ctrl.sv
module ebus_phase_ctrl
  import ebus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  timing_t    tim_i,
  input  logic       wr_i,
  input  logic       ready_i,
  output phase_e     phase_o,
  output logic [1:0] idx_o,
  output timing_t    tim_o,
  output logic       wr_o,
  output logic       strobe_end_o,
  output logic       step_o
);
  phase_e     state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [1:0] idx_q, idx_d;
  timing_t    tim_q;
  logic       wr_q;
  logic       cap_en;
  phase_e     nxt;
  phase_e     first_new, first_cur;

  assign cap_en    = (state_q == PH_IDLE) && start_i;
  assign first_new = (tim_i.pre != 4'd0) ? PH_PRE : PH_STROBE;
  assign first_cur = (tim_q.pre != 4'd0) ? PH_PRE : PH_STROBE;

  // phase after the current one within a transfer; PH_IDLE marks its end
  always_comb begin
    case (state_q)
      PH_PRE:    nxt = PH_STROBE;
      PH_STROBE: nxt = (tim_q.hold  != 4'd0) ? PH_HOLD  :
                       (tim_q.flt   != 4'd0) ? PH_FLOAT :
                       (tim_q.recov != 4'd0) ? PH_RECOV : PH_IDLE;
      PH_HOLD:   nxt = (tim_q.flt   != 4'd0) ? PH_FLOAT :
                       (tim_q.recov != 4'd0) ? PH_RECOV : PH_IDLE;
      PH_FLOAT:  nxt = (tim_q.recov != 4'd0) ? PH_RECOV : PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    idx_d        = idx_q;
    strobe_end_o = 1'b0;
    step_o       = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (start_i) begin
          idx_d   = 2'd0;
          state_d = first_new;
          cnt_d   = 4'(phase_len(first_new, tim_i) - 5'd1);
        end
      end
      PH_DONE: state_d = PH_IDLE;
      default: begin
        if (cnt_q != 4'd0) begin
          cnt_d = cnt_q - 4'd1;
        end else if (!(state_q == PH_STROBE && tim_q.wait_en && !ready_i)) begin
          strobe_end_o = (state_q == PH_STROBE);
          if (nxt != PH_IDLE) begin
            state_d = nxt;
            cnt_d   = 4'(phase_len(nxt, tim_q) - 5'd1);
          end else if (idx_q == last_index(tim_q.wsel)) begin
            state_d = PH_DONE;
          end else begin
            step_o  = 1'b1;
            idx_d   = idx_q + 2'd1;
            state_d = first_cur;
            cnt_d   = 4'(phase_len(first_cur, tim_q) - 5'd1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= 4'd0;
      idx_q   <= 2'd0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q <= '0;
      wr_q  <= 1'b0;
    end else if (cap_en) begin
      tim_q <= tim_i;
      wr_q  <= wr_i;
    end
  end

  assign phase_o = state_q;
  assign idx_o   = idx_q;
  assign tim_o   = tim_q;
  assign wr_o    = wr_q;
endmodule

// File: rtl/ebus_lane_unit.sv
module ebus_lane_unit
  import ebus_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  width_e            wsel_i,
  input  logic              autoinc_i,
  input  logic              wr_i,
  input  logic [1:0]        idx_i,
  input  logic              strobe_end_i,
  input  logic              step_i,
  input  logic [BUS_W-1:0]  bus_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BUS_W-1:0]  wdata_o,
  output logic [BUS_W-1:0]  rdata_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BUS_W-1:0]  wdata_q, wdata_d;
  logic [BUS_W-1:0]  rdata_q, rdata_d;
  logic [ADDR_W-1:0] stride;

  always_comb begin
    case (wsel_i)
      WID_8:   stride = ADDR_W'(1);
      WID_16:  stride = ADDR_W'(2);
      default: stride = ADDR_W'(4);
    endcase
  end

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    if (start_i) begin
      addr_d  = addr_i;
      wdata_d = wdata_i;
      rdata_d = '0;
    end else begin
      if (strobe_end_i && !wr_i) begin
        case (wsel_i)
          WID_8:   rdata_d[8*idx_i +: 8]     = bus_data_i[7:0];
          WID_16:  rdata_d[16*idx_i[0] +: 16] = bus_data_i[15:0];
          default: rdata_d                   = bus_data_i;
        endcase
      end
      if (step_i) begin
        if (autoinc_i) addr_d = addr_q + stride;
        wdata_d = (wsel_i == WID_16) ? (wdata_q >> 16) : (wdata_q >> 8);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ebus_access_seq.sv
module ebus_access_seq
  import ebus_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              dma_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       region_cfg_i,
  input  logic [15:0]       common_cfg_i,
  input  logic              ready_i,
  input  logic [31:0]       bus_data_i,
  output logic              bus_rd_n_o,
  output logic              bus_wr_n_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_data_o,
  output logic              bus_data_oe_o,
  output logic [31:0]       rdata_o,
  output logic              busy_o,
  output logic              done_o
);
  logic       rst_n_int;
  timing_t    tim_new, tim_cur;
  phase_e     phase;
  logic [1:0] idx;
  logic       wr_cur, strobe_end, step, start;
  logic       in_xfer;

  ebus_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  ebus_timing_decode u_dec (
    .region_cfg_i(region_cfg_i), .common_cfg_i(common_cfg_i),
    .wr_i(wr_i), .dma_i(dma_i), .tim_o(tim_new)
  );

  assign start = req_i && (phase == PH_IDLE);

  ebus_phase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .start_i(req_i), .tim_i(tim_new),
    .wr_i(wr_i), .ready_i(ready_i), .phase_o(phase), .idx_o(idx),
    .tim_o(tim_cur), .wr_o(wr_cur), .strobe_end_o(strobe_end), .step_o(step)
  );

  ebus_lane_unit #(.ADDR_W(ADDR_W)) u_lane (
    .clk(clk), .rst_n(rst_n_int), .start_i(start), .addr_i(addr_i),
    .wdata_i(wdata_i), .wsel_i(tim_cur.wsel), .autoinc_i(tim_cur.autoinc),
    .wr_i(wr_cur), .idx_i(idx), .strobe_end_i(strobe_end), .step_i(step),
    .bus_data_i(bus_data_i), .addr_o(bus_addr_o), .wdata_o(bus_data_o),
    .rdata_o(rdata_o)
  );

  assign in_xfer       = (phase != PH_IDLE) && (phase != PH_DONE);
  assign bus_rd_n_o    = !((phase == PH_STROBE) && !wr_cur);
  assign bus_wr_n_o    = !((phase == PH_STROBE) && wr_cur);
  assign bus_data_oe_o = in_xfer && wr_cur;
  assign busy_o        = (phase != PH_IDLE);
  assign done_o        = (phase == PH_DONE);
endmodule

// File: rtl/ebus_access_seq_chk.sv
module ebus_access_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_i,
  input logic bus_rd_n_o,
  input logic bus_wr_n_o,
  input logic busy_o,
  input logic done_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n_o && !bus_wr_n_o)); // R2

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n_o || !bus_wr_n_o) |-> busy_o); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R9

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o); // R9

  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !req_i) |=> !busy_o); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (bus_rd_n_o && bus_wr_n_o && !done_o)); // R1
endmodule

bind ebus_access_seq ebus_access_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_rd_n_o(bus_rd_n_o),
  .bus_wr_n_o(bus_wr_n_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_ebus_access_seq.sv
module tb_ebus_access_seq;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_i = 1'b0, wr_i = 1'b0, dma_i = 1'b0, ready_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0, region_cfg_i = '0;
  logic [15:0]   common_cfg_i = 16'h3125;
  logic [31:0]   bus_data_i;
  logic          bus_rd_n_o, bus_wr_n_o, bus_data_oe_o, busy_o, done_o;
  logic [AW-1:0] bus_addr_o;
  logic [31:0]   bus_data_o, rdata_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  // device model: every byte lane returns low address byte xor 5Ah
  assign bus_data_i = {4{bus_addr_o[7:0] ^ 8'h5A}};

  ebus_access_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .dma_i(dma_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .region_cfg_i(region_cfg_i),
    .common_cfg_i(common_cfg_i), .ready_i(ready_i), .bus_data_i(bus_data_i),
    .bus_rd_n_o(bus_rd_n_o), .bus_wr_n_o(bus_wr_n_o), .bus_addr_o(bus_addr_o),
    .bus_data_o(bus_data_o), .bus_data_oe_o(bus_data_oe_o), .rdata_o(rdata_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic        wr;
    logic        dma;
    logic [23:0] addr;
    logic [31:0] wdata;
    logic [2:0]  nx;
    logic [7:0]  lat;
    logic [7:0]  strb;
    logic [23:0] last;
    logic [31:0] rdat;
  } vec_t;

  // common word 3125h: recovery 5, hold 2, float 1, pre-strobe 3
  localparam vec_t VECS [7] = '{
    '{32'h0000_0043, 1'b0, 1'b0, 24'h000100, 32'h0,         3'd4, 8'd21, 8'd20, 24'h000100, 32'h5A5A5A5A},
    '{32'h0000_3243, 1'b1, 1'b0, 24'h000200, 32'h12345678,  3'd2, 8'd13, 8'd8,  24'h000202, 32'h0},
    '{32'h0000_2F43, 1'b0, 1'b0, 24'h000310, 32'h0,         3'd4, 8'd65, 8'd20, 24'h000313, 32'h49484B4A},
    '{32'h6700_1043, 1'b0, 1'b1, 24'h000420, 32'h0,         3'd1, 8'd9,  8'd8,  24'h000420, 32'h7A7A7A7A},
    '{32'h6700_1043, 1'b0, 1'b0, 24'h000500, 32'h0,         3'd2, 8'd11, 8'd10, 24'h000500, 32'h5A5A5A5A},
    '{32'h0000_01FF, 1'b1, 1'b0, 24'h000600, 32'hA1B2C3D4,  3'd4, 8'd85, 8'd64, 24'h000600, 32'h0},
    '{32'h4000_0200, 1'b1, 1'b1, 24'h000700, 32'hCAFEF00D,  3'd1, 8'd4,  8'd1,  24'h000700, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input bit poke,
                     output int lat, output int strb, output int falls,
                     output logic [23:0] last, output logic [31:0] acc);
    int pos, wbits;
    logic prev, s;
    logic [63:0] mask;
    wbits = 32 / int'(v.nx);
    mask  = (64'h1 << wbits) - 64'h1;
    @(negedge clk);
    region_cfg_i = v.cfg; wr_i = v.wr; dma_i = v.dma;
    addr_i = v.addr; wdata_i = v.wdata; req_i = 1'b1;
    lat = 0; strb = 0; falls = 0; last = '0; acc = '0; pos = 0; prev = 1'b1;
    while (1) begin
      @(negedge clk);
      req_i = 1'b0;
      lat++;
      if (poke && lat == 3) begin
        req_i = 1'b1; region_cfg_i = 32'h0000_0FFF; wdata_i = 32'hFFFF_FFFF;
      end
      s = v.wr ? bus_wr_n_o : bus_rd_n_o;
      if (!s) begin
        strb++;
        last = bus_addr_o;
        if (prev) begin
          falls++;
          acc = acc | 32'((64'(bus_data_o) & mask) << pos);
          pos += wbits;
        end
      end
      prev = s;
      if (done_o || lat > 2000) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int lat, strb, falls;
    logic [23:0] last;
    logic [31:0] acc;

    // R1: reset state while held and after release
    repeat (3) @(negedge clk);
    chk("R1 rd_n in reset", {31'b0, bus_rd_n_o}, 32'd1);
    chk("R1 wr_n in reset", {31'b0, bus_wr_n_o}, 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", {31'b0, busy_o}, 32'd0);
    chk("R1 done after reset", {31'b0, done_o}, 32'd0);
    chk("R1 strobes after reset", {30'b0, bus_rd_n_o, bus_wr_n_o}, 32'd3);

    // table: R2 R3 R4 R5 R6 R7 R9; ready_i low throughout (R8 ignored)
    for (int i = 0; i < 7; i++) begin
      run(VECS[i], 1'b0, lat, strb, falls, last, acc);
      chk($sformatf("R9 latency v%0d", i), 32'(lat), 32'(VECS[i].lat));
      chk($sformatf("R2 R3 R5 strobe cycles v%0d", i), 32'(strb), 32'(VECS[i].strb));
      chk($sformatf("R7 last address v%0d", i), 32'(last), 32'(VECS[i].last));
      if (VECS[i].wr) begin
        chk($sformatf("R4 R6 transfers v%0d", i), 32'(falls), 32'(VECS[i].nx));
        chk($sformatf("R4 write parts v%0d", i), acc, VECS[i].wdata);
      end else begin
        chk($sformatf("R4 R6 read word v%0d", i), rdata_o, VECS[i].rdat);
      end
      @(negedge clk);
      chk($sformatf("R9 idle after done v%0d", i), {31'b0, busy_o}, 32'd0);
    end

    // R9: request while busy is ignored
    run(VECS[1], 1'b1, lat, strb, falls, last, acc);
    chk("R9 busy request latency", 32'(lat), 32'd13);
    chk("R9 busy request data", acc, 32'h12345678);
    @(negedge clk);
    chk("R9 busy request not restarted", {31'b0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R9 still idle", {31'b0, busy_o}, 32'd0);

    // R8: wait on ready, one 32-bit DMA read with 1-cycle strobe
    region_cfg_i = 32'hC000_0000; wr_i = 1'b0; dma_i = 1'b1;
    addr_i = 24'h000800; ready_i = 1'b0; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    repeat (9) @(negedge clk);
    chk("R8 strobe held while not ready", {31'b0, bus_rd_n_o}, 32'd0);
    chk("R8 no done while not ready", {31'b0, done_o}, 32'd0);
    ready_i = 1'b1;
    @(negedge clk);
    chk("R8 done after ready", {31'b0, done_o}, 32'd1);
    chk("R8 read word", rdata_o, 32'h5A5A5A5A);
    ready_i = 1'b0;
    @(negedge clk);
    chk("R8 idle", {31'b0, busy_o}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule